// File: doc/BRIEF.md
# Supply Rail Power-Up and Shutdown Sequencer

This block is the control core of a board power manager. It watches conditioned status flags from the rail comparators and steps through a fixed supervisory program. First it waits for the analog front end to report ready and parks every output in its inactive state. Next it waits for the backplane 5 V and 3.3 V rails and turns on the soft-start switch. It then enables the 2.5 V converter, followed by the 1.8 V core converter, each after the rail before it reports good. A reset-stretch delay follows, after which the CPU leaves reset and power-good goes high.

While running, any rail that should be on and reports not-OK starts the shutdown program. The sequencer raises a one-cycle supply-fault interrupt and drops power-good. It then waits a save-state delay for the processor, puts the CPU back in reset and switches off the rails in reverse order. Each rail must report below its minimum before the next one is dropped. The program ends in a terminal halt that only a reset leaves.

Both delays come from step timers. The timers count ticks of a prescaled clock, which is 4 µs per tick with the default parameters. Each timer reloads when the program enters the step that uses it. Every output is a flop, so no output can glitch.

Top module: `rail_sequencer`

## Requirements
- R1: While reset is asserted, and until `analog_ready` has been seen high, the outputs hold their idle values: `ss_en`=0, `en_2v5`=0, `en_1v8`=0, `cpu_reset`=1, `supply_irq`=0, `pwr_good`=0. One cycle after `analog_ready` is sampled high, the program takes a single initialise step that keeps these values.
- R2: The prescaler issues one tick every `CLK_DIV` clock cycles, and the first tick is in cycle `CLK_DIV`-1 after reset. A timer loads its count on the edge that enters its step and decrements once per tick. Its step ends on the edge after the count reaches zero.
- R3: `ss_en` rises on the edge after both `bp5_ok` and `bp3v3_ok` are sampled high, and never earlier.
- R4: With `ss_en` on, `en_2v5` rises on the edge after `ss3v3_ok` is sampled high.
- R5: With `en_2v5` on, `en_1v8` rises on the edge after `rail2v5_ok` is sampled high.
- R6: When all five OK inputs are sampled high, a stretch of `T1_TICKS` ticks runs. On the edge after it ends, `cpu_reset` falls and `pwr_good` rises in the same cycle.
- R7: While running, a low on any of the five OK inputs raises `supply_irq` for exactly one cycle. `pwr_good` falls on that same edge.
- R8: After the interrupt cycle, a save wait of `T2_TICKS` ticks runs. On the edge after it ends, `cpu_reset` rises and `en_1v8` falls together.
- R9: `en_2v5` falls on the edge after `rail1v8_on` is sampled low. Then `ss_en` falls on the edge after `rail2v5_on` is sampled low.
- R10: After shutdown the program halts. All inputs are ignored and the outputs hold their idle values until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| analog_ready | input | 1 | Analog front end ready to monitor |
| bp5_ok | input | 1 | Backplane 5 V within window |
| bp3v3_ok | input | 1 | Backplane 3.3 V within window |
| ss3v3_ok | input | 1 | Soft-started 3.3 V within window |
| rail2v5_ok | input | 1 | 2.5 V rail within window |
| rail1v8_ok | input | 1 | 1.8 V core rail within window |
| rail2v5_on | input | 1 | 2.5 V rail above its minimum |
| rail1v8_on | input | 1 | 1.8 V rail above its minimum |
| ss_en | output | 1 | Backplane soft-start switch enable |
| en_2v5 | output | 1 | 2.5 V converter enable |
| en_1v8 | output | 1 | 1.8 V converter enable |
| cpu_reset | output | 1 | CPU reset, 1 = held in reset |
| supply_irq | output | 1 | Supply-fault interrupt pulse |
| pwr_good | output | 1 | All rails up and CPU released |

## Verification
A wrong step register shows up at the enables within one clock. The sequencer either moves before the flag it waits for or misses it, so an enable rises or falls a cycle early or late. A wrong timer or prescaler count only shows when `pwr_good` rises or when `en_1v8` falls, and that can be several hundred cycles after the step was entered. For this reason the bench compares all six outputs against its reference model on every cycle and also measures each delay window in cycles. A halt that is not terminal shows up as an enable coming back on while the inputs are toggled after shutdown.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;

    typedef enum logic [3:0] {
        ST_ANALOG,
        ST_INIT,
        ST_WAIT_BP,
        ST_WAIT_SS,
        ST_WAIT_2V5,
        ST_WAIT_ALL,
        ST_STRETCH,
        ST_RUN,
        ST_IRQ,
        ST_SAVE,
        ST_OFF_1V8,
        ST_OFF_2V5,
        ST_HALT
    } seq_state_e;

    typedef struct packed {
        logic ss_en;
        logic en_2v5;
        logic en_1v8;
        logic cpu_reset;
        logic irq;
        logic pwr_good;
    } seq_out_t;

    localparam seq_out_t OUT_IDLE = '{ss_en: 1'b0, en_2v5: 1'b0, en_1v8: 1'b0,
                                      cpu_reset: 1'b1, irq: 1'b0, pwr_good: 1'b0};

    typedef struct packed {
        seq_state_e state;
        seq_out_t   outs;
    } seq_regs_t;

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
    parameter int DIV = 1000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == LAST);
        cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    generate
        if (DIV > 1) begin : g_tick_chk
            // ticks never come back to back when dividing
            assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/step_timer.sv
module step_timer #(
    parameter int W = 19
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)                    cnt_d = load_val;
        else if (tick && cnt_q != 0) cnt_d = cnt_q - 1'b1;
        done = (cnt_q == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // an expired timer stays expired until reloaded (no wrap below zero)
    assert_timer_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q == '0) |=> (cnt_q == '0));
    // a tick without load never lets the count grow
    assert_timer_monotonic_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (cnt_q <= $past(cnt_q)));
endmodule

// File: rtl/rail_sequencer.sv
module rail_sequencer
    import rail_seq_pkg::*;
#(
    parameter int CLK_DIV  = 1000,
    parameter int TMR_W    = 19,
    parameter int T1_TICKS = 255,
    parameter int T2_TICKS = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic analog_ready,
    input  logic bp5_ok,
    input  logic bp3v3_ok,
    input  logic ss3v3_ok,
    input  logic rail2v5_ok,
    input  logic rail1v8_ok,
    input  logic rail2v5_on,
    input  logic rail1v8_on,
    output logic ss_en,
    output logic en_2v5,
    output logic en_1v8,
    output logic cpu_reset,
    output logic supply_irq,
    output logic pwr_good
);
    localparam logic [TMR_W-1:0] T1_VAL = TMR_W'(T1_TICKS);
    localparam logic [TMR_W-1:0] T2_VAL = TMR_W'(T2_TICKS);

    seq_regs_t regs_d, regs_q;
    logic tick, t1_load, t2_load, t1_done, t2_done, all_ok;

    tick_prescaler #(.DIV(CLK_DIV)) u_prescaler (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    step_timer #(.W(TMR_W)) u_stretch_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .load(t1_load), .load_val(T1_VAL), .done(t1_done)
    );

    step_timer #(.W(TMR_W)) u_save_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .load(t2_load), .load_val(T2_VAL), .done(t2_done)
    );

    always_comb begin
        regs_d  = regs_q;
        t1_load = 1'b0;
        t2_load = 1'b0;
        all_ok  = bp5_ok & bp3v3_ok & ss3v3_ok & rail2v5_ok & rail1v8_ok;
        unique case (regs_q.state)
            ST_ANALOG:
                if (analog_ready) regs_d.state = ST_INIT;
            ST_INIT: begin
                regs_d.outs  = OUT_IDLE;
                regs_d.state = ST_WAIT_BP;
            end
            ST_WAIT_BP:
                if (bp5_ok && bp3v3_ok) begin
                    regs_d.outs.ss_en = 1'b1;
                    regs_d.state      = ST_WAIT_SS;
                end
            ST_WAIT_SS:
                if (ss3v3_ok) begin
                    regs_d.outs.en_2v5 = 1'b1;
                    regs_d.state       = ST_WAIT_2V5;
                end
            ST_WAIT_2V5:
                if (rail2v5_ok) begin
                    regs_d.outs.en_1v8 = 1'b1;
                    regs_d.state       = ST_WAIT_ALL;
                end
            ST_WAIT_ALL:
                if (all_ok) begin
                    t1_load      = 1'b1;
                    regs_d.state = ST_STRETCH;
                end
            ST_STRETCH:
                if (t1_done) begin
                    regs_d.outs.cpu_reset = 1'b0;
                    regs_d.outs.pwr_good  = 1'b1;
                    regs_d.state          = ST_RUN;
                end
            ST_RUN:
                if (!all_ok) begin
                    regs_d.outs.irq      = 1'b1;
                    regs_d.outs.pwr_good = 1'b0;
                    regs_d.state         = ST_IRQ;
                end
            ST_IRQ: begin
                regs_d.outs.irq = 1'b0;
                t2_load         = 1'b1;
                regs_d.state    = ST_SAVE;
            end
            ST_SAVE:
                if (t2_done) begin
                    regs_d.outs.cpu_reset = 1'b1;
                    regs_d.outs.en_1v8    = 1'b0;
                    regs_d.state          = ST_OFF_1V8;
                end
            ST_OFF_1V8:
                if (!rail1v8_on) begin
                    regs_d.outs.en_2v5 = 1'b0;
                    regs_d.state       = ST_OFF_2V5;
                end
            ST_OFF_2V5:
                if (!rail2v5_on) begin
                    regs_d.outs.ss_en = 1'b0;
                    regs_d.state      = ST_HALT;
                end
            ST_HALT: ;
            default: begin
                regs_d.outs  = OUT_IDLE;
                regs_d.state = ST_HALT;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.state <= ST_ANALOG;
            regs_q.outs  <= OUT_IDLE;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign ss_en      = regs_q.outs.ss_en;
    assign en_2v5     = regs_q.outs.en_2v5;
    assign en_1v8     = regs_q.outs.en_1v8;
    assign cpu_reset  = regs_q.outs.cpu_reset;
    assign supply_irq = regs_q.outs.irq;
    assign pwr_good   = regs_q.outs.pwr_good;

    assert_ss_after_bp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ss_en) |-> $past(bp5_ok && bp3v3_ok));
    assert_2v5_needs_ss_R4: assert property (@(posedge clk) disable iff (!rst_n)
        en_2v5 |-> ss_en);
    assert_1v8_needs_2v5_R5: assert property (@(posedge clk) disable iff (!rst_n)
        en_1v8 |-> en_2v5);
    assert_pg_rails_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_good |-> (en_1v8 && !cpu_reset && !supply_irq));
    assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        supply_irq |=> !supply_irq);
    assert_halt_sticks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.state == ST_HALT) |=> (regs_q.state == ST_HALT && !ss_en && cpu_reset));
endmodule

// File: tb/rail_sequencer_bench.sv
module rail_sequencer_bench;
    localparam int DIV = 4;
    localparam int T1  = 6;
    localparam int T2  = 10;
    localparam int WATCHDOG = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic analog_ready = 0, bp5_ok = 0, bp3v3_ok = 0, ss3v3_ok = 0;
    logic rail2v5_ok = 0, rail1v8_ok = 0, rail2v5_on = 0, rail1v8_on = 0;
    logic ss_en, en_2v5, en_1v8, cpu_reset, supply_irq, pwr_good;

    int checks = 0, failures = 0, cyc = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    rail_sequencer #(.CLK_DIV(DIV), .TMR_W(8), .T1_TICKS(T1), .T2_TICKS(T2)) u_rail_sequencer (
        .clk(clk), .rst_n(rst_n), .analog_ready(analog_ready),
        .bp5_ok(bp5_ok), .bp3v3_ok(bp3v3_ok), .ss3v3_ok(ss3v3_ok),
        .rail2v5_ok(rail2v5_ok), .rail1v8_ok(rail1v8_ok),
        .rail2v5_on(rail2v5_on), .rail1v8_on(rail1v8_on),
        .ss_en(ss_en), .en_2v5(en_2v5), .en_1v8(en_1v8),
        .cpu_reset(cpu_reset), .supply_irq(supply_irq), .pwr_good(pwr_good)
    );

    // reference model: program step numbers, integer timers
    int m_step = 1, m_t1 = 0, m_t2 = 0, m_pc = 0;
    bit m_ss = 0, m_e25 = 0, m_e18 = 0, m_rst = 1, m_irq = 0, m_pg = 0;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_step = 1; m_t1 = 0; m_t2 = 0; m_pc = 0;
            m_ss = 0; m_e25 = 0; m_e18 = 0; m_rst = 1; m_irq = 0; m_pg = 0;
        end else begin
            bit tk, ld1, ld2, ok5;
            int nstep;
            tk = (m_pc % DIV) == DIV - 1;
            m_pc++;
            ld1 = 0; ld2 = 0; nstep = m_step;
            ok5 = bp5_ok && bp3v3_ok && ss3v3_ok && rail2v5_ok && rail1v8_ok;
            case (m_step)
                1:  if (analog_ready) nstep = 2;
                2:  nstep = 3;
                3:  if (bp5_ok && bp3v3_ok) begin m_ss = 1; nstep = 5; end
                5:  if (ss3v3_ok) begin m_e25 = 1; nstep = 7; end
                7:  if (rail2v5_ok) begin m_e18 = 1; nstep = 9; end
                9:  if (ok5) begin ld1 = 1; nstep = 10; end
                10: if (m_t1 == 0) begin m_rst = 0; m_pg = 1; nstep = 12; end
                12: if (!ok5) begin m_irq = 1; m_pg = 0; nstep = 14; end
                14: begin m_irq = 0; ld2 = 1; nstep = 16; end
                16: if (m_t2 == 0) begin m_rst = 1; m_e18 = 0; nstep = 18; end
                18: if (!rail1v8_on) begin m_e25 = 0; nstep = 20; end
                20: if (!rail2v5_on) begin m_ss = 0; nstep = 22; end
                default: ;
            endcase
            if (ld1) m_t1 = T1; else if (tk && m_t1 > 0) m_t1--;
            if (ld2) m_t2 = T2; else if (tk && m_t2 > 0) m_t2--;
            m_step = nstep;
        end
    end

    function automatic string tag_of(int s);
        case (s)
            1, 2:   return "R1";
            3, 5:   return "R3";
            7:      return "R4";
            9:      return "R5";
            10:     return "R6";
            12, 14: return "R7";
            16:     return "R8";
            18, 20: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // compare every output with the model on every cycle
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            string t;
            t = tag_of(m_step);
            chk(ss_en == m_ss, t, "ss_en", ss_en, m_ss);
            chk(en_2v5 == m_e25, t, "en_2v5", en_2v5, m_e25);
            chk(en_1v8 == m_e18, t, "en_1v8", en_1v8, m_e18);
            chk(cpu_reset == m_rst, t, "cpu_reset", cpu_reset, m_rst);
            chk(supply_irq == m_irq, t, "supply_irq", supply_irq, m_irq);
            chk(pwr_good == m_pg, t, "pwr_good", pwr_good, m_pg);
        end
    end

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_idle(string tag);
        chk({ss_en, en_2v5, en_1v8, cpu_reset, supply_irq, pwr_good} == 6'b000100,
            tag, "idle outputs", {ss_en, en_2v5, en_1v8, cpu_reset, supply_irq, pwr_good}, 6'b000100);
    endtask

    task automatic summary();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > WATCHDOG && !finished) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, WATCHDOG);
            summary();
        end
    end

    initial begin
        int c0, lo, hi;
        cycles(3);
        check_idle("R1");                       // held in reset
        rst_n = 1;
        cycles(6);
        check_idle("R1");                       // no analog_ready yet
        analog_ready = 1; bp5_ok = 1;
        cycles(6);
        chk(ss_en == 0, "R3", "ss_en with only 5V ok", ss_en, 0);
        bp3v3_ok = 1;
        cycles(2);
        chk(ss_en == 1, "R3", "ss_en after both backplane ok", ss_en, 1);
        cycles(4);
        chk(en_2v5 == 0, "R4", "en_2v5 before ss ok", en_2v5, 0);
        ss3v3_ok = 1;
        cycles(2);
        chk(en_2v5 == 1, "R4", "en_2v5 after ss ok", en_2v5, 1);
        rail2v5_ok = 1; rail2v5_on = 1;
        cycles(2);
        chk(en_1v8 == 1, "R5", "en_1v8 after 2v5 ok", en_1v8, 1);
        rail1v8_ok = 1; rail1v8_on = 1;
        while (m_step != 10) cycles(1);
        c0 = cyc;
        while (!pwr_good && cyc < c0 + 1000) cycles(1);
        lo = (T1 - 1) * DIV + 2; hi = T1 * DIV + 1;
        chk((cyc - c0) >= lo && (cyc - c0) <= hi, "R2", "stretch length", cyc - c0, lo);
        chk(cpu_reset == 0 && pwr_good == 1, "R6", "cpu released with power good",
            {cpu_reset, pwr_good}, 2'b01);
        cycles(20);
        chk(pwr_good == 1 && supply_irq == 0, "R7", "no fault while running", pwr_good, 1);
        rail2v5_ok = 0;
        cycles(1);
        chk(supply_irq == 1 && pwr_good == 0, "R7", "fault interrupt", {supply_irq, pwr_good}, 2'b10);
        cycles(1);
        chk(supply_irq == 0, "R7", "interrupt is one cycle", supply_irq, 0);
        c0 = cyc;
        while (en_1v8 && cyc < c0 + 1000) cycles(1);
        lo = (T2 - 1) * DIV + 2; hi = T2 * DIV + 1;
        chk((cyc - c0) >= lo && (cyc - c0) <= hi, "R8", "save wait length", cyc - c0, lo);
        chk(cpu_reset == 1, "R8", "cpu back in reset", cpu_reset, 1);
        cycles(5);
        chk(en_2v5 == 1, "R9", "2v5 held while 1v8 on", en_2v5, 1);
        rail1v8_on = 0; rail1v8_ok = 0;
        cycles(2);
        chk(en_2v5 == 0 && ss_en == 1, "R9", "2v5 off, ss still on", {en_2v5, ss_en}, 2'b01);
        rail2v5_on = 0;
        cycles(2);
        chk(ss_en == 0, "R9", "soft-start off", ss_en, 0);
        for (int i = 0; i < 30; i++) begin
            {analog_ready, bp5_ok, bp3v3_ok, ss3v3_ok, rail2v5_ok, rail1v8_ok,
             rail2v5_on, rail1v8_on} = 8'(i * 37 + 5);
            cycles(1);
        end
        check_idle("R10");                      // halt ignores inputs

        // second run: everything good at once, reset in the middle of the stretch
        rst_n = 0;
        {analog_ready, bp5_ok, bp3v3_ok, ss3v3_ok, rail2v5_ok, rail1v8_ok,
         rail2v5_on, rail1v8_on} = 8'hFF;
        cycles(2);
        check_idle("R1");
        rst_n = 1;
        while (m_step != 10) cycles(1);
        cycles(3);
        rst_n = 0;
        cycles(2);
        check_idle("R1");                       // reset mid sequence
        rst_n = 1;
        while (!pwr_good && cyc < 90000) cycles(1);
        cycles(7);
        bp5_ok = 0;                             // backplane fault
        cycles(1);
        chk(supply_irq == 1, "R7", "fault from backplane 5V", supply_irq, 1);
        rail1v8_on = 0; rail2v5_on = 0;         // rails already collapsed
        while (m_step != 22 && cyc < 90000) cycles(1);
        cycles(2);
        check_idle("R10");
        cycles(5);
        summary();
    end
endmodule